// File: doc/BRIEF.md
# Slow-Clock Reset Sequencer with Cause Reporting

This block runs on the always-on slow clock and decides when the processor and the peripherals come out of reset. It watches three sources: an asynchronous active-low general reset, a backup-wakeup request from the supply logic, and the level of an open-drain external reset pin. The sequencer holds both reset outputs low while a sequence is in progress. It can pull the external pin low for a programmable stretch, and it releases the resets only after the pin is seen high and a fixed startup delay has run out.

When the processor reset is released, the block records a 3-bit code for the source that started the sequence, and sets a sticky flag if that source was a user reset. A small register port gives software a mode register and a status register. The mode register holds the user-reset enable and the pin-stretch length. The status register holds the cause code, the sticky flag and the synchronized pin level.

Sources are ranked: general above backup above user. A higher-ranked request arriving while a sequence is in progress restarts the sequence under its own code. A request of equal or lower rank is ignored. The block never takes its own pin drive as a user reset.

Top module: `reset_cause_ctrl`

## Requirements
- R1: A low synchronized pin level in the running state starts a user reset only when the enable bit (mode bit 0) is 1. With the bit at 0, a low pin leaves both reset outputs high.
- R2: The pin input passes through a two-flop synchronizer on `clk`. Status bit 16 reads the synchronized level.
- R3: A user reset drives `procRstN` and `periphRstN` low on the third rising edge after the pin falls. It does not drive the pin itself (`pinDriveN` stays 1).
- R4: Both reset outputs return high on the sixth rising edge after the pin rises. That is two synchronizer cycles, one detection cycle and a three-cycle startup.
- R5: The cause code (status bits 2:0) changes only on the edge that releases `procRstN`. After a user reset it reads 4, and the sticky user flag (status bit 8) is set.
- R6: `genRstN` low asynchronously forces both reset outputs low and `pinDriveN` low, and clears the mode register and the cause code. After release, the cause reads 0.
- R7: `bkupRst` sampled high while running drives both resets and the pin low on the next edge. After release, the cause reads 1.
- R8: For a general or backup sequence, `pinDriveN` is low for exactly 2^(L+1) cycles, where L is mode bits 7:4. The resets are low whenever the pin is driven.
- R9: If the pin is still held low from outside after the stretch, both resets stay low until it rises. They are then released per R4.
- R10: The block's own pin drive never produces a user reset. After a backup or general sequence, the resets stay released while the pin stays high.
- R11: A backup request during a user sequence restarts the sequence with code 1. A backup request during a general or backup sequence has no effect on its timing.
- R12: A status read (`regRe` with `regAddr`=1) clears the sticky user flag.
- R13: Writing `regAddr`=0 loads mode bit 0 and bits 7:4. Reading `regAddr`=0 returns them in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| genRstN | input | 1 | General reset, active low, asynchronous |
| bkupRst | input | 1 | Backup-wakeup reset request, active high |
| pinIn | input | 1 | Sensed level of the external reset pin |
| pinDriveN | output | 1 | 0 pulls the external reset pin low |
| procRstN | output | 1 | Processor reset, active low |
| periphRstN | output | 1 | Peripheral reset, active low |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 = mode register, 1 = status register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data |

## Verification
The assertions check four things on every cycle. The resets stay high with the user enable off and no backup request. A backup request in the running state enters a pin-driving sequence on the next edge. A pin drive never coexists with released resets. The cause code moves only on a release edge, and every entry into reset follows either a backup request or a low synchronized pin. Only the bench scenarios can show the exact stretch lengths for several length settings, and the three- and six-edge entry and release latencies. They also show which code wins when sources overlap, the externally held pin, and the clearing of the sticky flag on a status read.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef enum logic [2:0] {
    ST_PIN     = 3'd0,
    ST_WAITHI  = 3'd1,
    ST_START   = 3'd2,
    ST_USERLOW = 3'd3,
    ST_RUN     = 3'd4
  } seqState_e;

  localparam logic [2:0] CAUSE_GEN  = 3'd0;
  localparam logic [2:0] CAUSE_BKUP = 3'd1;
  localparam logic [2:0] CAUSE_USER = 3'd4;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       loadStretch;
    logic       loadStartup;
    logic       decCount;
    logic       latchCause;
    logic [2:0] causeCode;
  } ctlStrobe_t;

endpackage

// File: rtl/rstc_datapath.sv
module rstc_datapath
  import rstc_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STARTUP_CYC = 3,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              genRstN,
  input  logic              pinIn,
  input  ctlStrobe_t        ctl,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              pinSync,
  output logic              userEn,
  output logic              cntZero,
  output logic [2:0]        causeOut
);

  localparam int CNT_W          = (1 << LEN_W) + 1;
  localparam int SH_W           = LEN_W + 1;
  localparam int MODE_EN_BIT    = 0;
  localparam int MODE_LEN_LSB   = 4;
  localparam int STS_STICKY_BIT = 8;
  localparam int STS_PIN_BIT    = 16;
  localparam logic [CNT_W-1:0] START_LOAD = CNT_W'(STARTUP_CYC - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   userEnQ;
  logic [LEN_W-1:0]       extLenQ;
  logic [CNT_W-1:0]       cntQ;
  logic [CNT_W-1:0]       stretchVal;
  logic [SH_W-1:0]        shAmt;
  logic [2:0]             causeQ;
  logic                   stickyQ;
  logic                   statusRead;
  logic                   unusedWdata;

  // Pin synchronizer
  always_ff @(posedge clk or negedge genRstN) begin
    if (!genRstN) syncQ <= '0;
    else          syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  // Mode register
  always_ff @(posedge clk or negedge genRstN) begin
    if (!genRstN) begin
      userEnQ <= 1'b0;
      extLenQ <= '0;
    end else if (regWe && !regAddr) begin
      userEnQ <= regWdata[MODE_EN_BIT];
      extLenQ <= regWdata[MODE_LEN_LSB +: LEN_W];
    end
  end
  assign userEn = userEnQ;

  // Shared down counter: pin stretch and processor startup
  assign shAmt      = SH_W'(extLenQ) + SH_W'(1);
  assign stretchVal = (CNT_W'(1) << shAmt) - CNT_W'(1);

  always_ff @(posedge clk or negedge genRstN) begin
    if (!genRstN)             cntQ <= CNT_W'(1);
    else if (ctl.loadStretch) cntQ <= stretchVal;
    else if (ctl.loadStartup) cntQ <= START_LOAD;
    else if (ctl.decCount)    cntQ <= cntQ - CNT_W'(1);
  end
  assign cntZero = (cntQ == '0);

  // Cause code and sticky user flag
  assign statusRead = regRe && regAddr;

  always_ff @(posedge clk or negedge genRstN) begin
    if (!genRstN) begin
      causeQ  <= CAUSE_GEN;
      stickyQ <= 1'b0;
    end else begin
      if (ctl.latchCause) causeQ <= ctl.causeCode;
      if (ctl.latchCause && ctl.causeCode == CAUSE_USER) stickyQ <= 1'b1;
      else if (statusRead)                               stickyQ <= 1'b0;
    end
  end
  assign causeOut = causeQ;

  // Read mux
  always_comb begin
    regRdata = '0;
    if (!regAddr) begin
      regRdata[MODE_EN_BIT]                = userEnQ;
      regRdata[MODE_LEN_LSB +: LEN_W]      = extLenQ;
    end else begin
      regRdata[2:0]            = causeQ;
      regRdata[STS_STICKY_BIT] = stickyQ;
      regRdata[STS_PIN_BIT]    = pinSync;
    end
  end

  assign unusedWdata = ^{regWdata[DATA_W-1:MODE_LEN_LSB+LEN_W],
                         regWdata[MODE_LEN_LSB-1:MODE_EN_BIT+1]};

endmodule

// File: rtl/rstc_control.sv
module rstc_control
  import rstc_pkg::*;
(
  input  logic       clk,
  input  logic       genRstN,
  input  logic       bkupRst,
  input  logic       pinSync,
  input  logic       userEn,
  input  logic       cntZero,
  output ctlStrobe_t ctl,
  output logic       procRstN,
  output logic       periphRstN,
  output logic       pinDriveN
);

  seqState_e stateQ, stateNext;
  logic [2:0] pendQ, pendNext;
  logic       pinBusy;
  logic       bkupTake;
  logic       userTake;

  // Own-drive mask: pin is ours while stretching or waiting for it to settle
  assign pinBusy  = (stateQ == ST_PIN) || (stateQ == ST_WAITHI);
  assign bkupTake = bkupRst && ((stateQ == ST_RUN) || (pendQ == CAUSE_USER));
  assign userTake = (stateQ == ST_RUN) && userEn && !pinSync && !pinBusy;

  always_comb begin
    stateNext     = stateQ;
    pendNext      = pendQ;
    ctl           = '0;
    ctl.causeCode = pendQ;
    if (bkupTake) begin
      stateNext       = ST_PIN;
      pendNext        = CAUSE_BKUP;
      ctl.loadStretch = 1'b1;
    end else begin
      unique case (stateQ)
        ST_PIN: begin
          if (cntZero) stateNext = ST_WAITHI;
          else         ctl.decCount = 1'b1;
        end
        ST_WAITHI, ST_USERLOW: begin
          if (pinSync) begin
            stateNext       = ST_START;
            ctl.loadStartup = 1'b1;
          end
        end
        ST_START: begin
          if (cntZero) begin
            stateNext      = ST_RUN;
            ctl.latchCause = 1'b1;
          end else begin
            ctl.decCount = 1'b1;
          end
        end
        ST_RUN: begin
          if (userTake) begin
            stateNext = ST_USERLOW;
            pendNext  = CAUSE_USER;
          end
        end
        default: stateNext = ST_PIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge genRstN) begin
    if (!genRstN) begin
      stateQ <= ST_PIN;
      pendQ  <= CAUSE_GEN;
    end else begin
      stateQ <= stateNext;
      pendQ  <= pendNext;
    end
  end

  assign procRstN   = (stateQ == ST_RUN);
  assign periphRstN = (stateQ == ST_RUN);
  assign pinDriveN  = (stateQ != ST_PIN);

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rstc_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STARTUP_CYC = 3,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              genRstN,
  input  logic              bkupRst,
  input  logic              pinIn,
  output logic              pinDriveN,
  output logic              procRstN,
  output logic              periphRstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata
);

  ctlStrobe_t ctl;
  logic       pinSyncW;
  logic       userEnW;
  logic       cntZeroW;
  logic [2:0] causeW;

  rstc_control u_ctl (
    .clk        (clk),
    .genRstN    (genRstN),
    .bkupRst    (bkupRst),
    .pinSync    (pinSyncW),
    .userEn     (userEnW),
    .cntZero    (cntZeroW),
    .ctl        (ctl),
    .procRstN   (procRstN),
    .periphRstN (periphRstN),
    .pinDriveN  (pinDriveN)
  );

  rstc_datapath #(
    .LEN_W       (LEN_W),
    .SYNC_STAGES (SYNC_STAGES),
    .STARTUP_CYC (STARTUP_CYC),
    .DATA_W      (DATA_W)
  ) u_dp (
    .clk      (clk),
    .genRstN  (genRstN),
    .pinIn    (pinIn),
    .ctl      (ctl),
    .regWe    (regWe),
    .regRe    (regRe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pinSync  (pinSyncW),
    .userEn   (userEnW),
    .cntZero  (cntZeroW),
    .causeOut (causeW)
  );

endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk (
  input logic       clk,
  input logic       genRstN,
  input logic       bkupRst,
  input logic       userEn,
  input logic       pinSync,
  input logic [2:0] cause,
  input logic       procRstN,
  input logic       periphRstN,
  input logic       pinDriveN
);

  p_no_user_when_off_r1: assert property (@(posedge clk) disable iff (!genRstN)
    (procRstN && !userEn && !bkupRst) |=> procRstN);

  p_entry_has_source_r3: assert property (@(posedge clk) disable iff (!genRstN)
    $fell(procRstN) |-> ($past(bkupRst) || !$past(pinSync)));

  p_cause_moves_on_release_r5: assert property (@(posedge clk) disable iff (!genRstN)
    $stable(procRstN) |-> $stable(cause));

  p_cause_legal_r5: assert property (@(posedge clk) disable iff (!genRstN)
    (cause == 3'd0) || (cause == 3'd1) || (cause == 3'd4));

  p_backup_enters_r7: assert property (@(posedge clk) disable iff (!genRstN)
    (procRstN && bkupRst) |=> (!procRstN && !pinDriveN));

  p_drive_holds_reset_r8: assert property (@(posedge clk) disable iff (!genRstN)
    !pinDriveN |-> (!procRstN && !periphRstN));

endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk u_chk (
  .clk        (clk),
  .genRstN    (genRstN),
  .bkupRst    (bkupRst),
  .userEn     (userEnW),
  .pinSync    (pinSyncW),
  .cause      (causeW),
  .procRstN   (procRstN),
  .periphRstN (periphRstN),
  .pinDriveN  (pinDriveN)
);

// File: tb/reset_cause_ctrl_test.sv
`timescale 1ns/1ps
module reset_cause_ctrl_test;

  logic        clk = 1'b0;
  logic        genRstN = 1'b0;
  logic        bkupRst = 1'b0;
  logic        extN = 1'b1;
  logic        pinIn;
  logic        pinDriveN, procRstN, periphRstN;
  logic        regWe = 1'b0, regRe = 1'b0, regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  // Open-drain pin: low if either side pulls it
  assign pinIn = pinDriveN & extN;

  reset_cause_ctrl uut (
    .clk(clk), .genRstN(genRstN), .bkupRst(bkupRst), .pinIn(pinIn),
    .pinDriveN(pinDriveN), .procRstN(procRstN), .periphRstN(periphRstN),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  localparam int VEC_N = 4;
  localparam int vecLen [VEC_N] = '{0, 1, 3, 5};
  localparam int vecLow [VEC_N] = '{2, 4, 16, 64};
  localparam int EXP_RISE  = 6;
  localparam int EXP_ENTRY = 3;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeMode(input logic [31:0] d);
    regWe = 1'b1; regAddr = 1'b0; regWdata = d;
    tick();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic peek(input logic a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic countDrive(output int n);
    n = 0;
    while (!pinDriveN && n < 100000) begin tick(); n++; end
  endtask

  task automatic countToHigh(output int n);
    n = 0;
    while (!procRstN && n < 100000) begin tick(); n++; end
  endtask

  task automatic countToLow(output int n);
    n = 0;
    while (procRstN && n < 100000) begin tick(); n++; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    int stayed;

    // Reset state (R6)
    tick(); tick();
    check("R6 procRstN in reset", int'(procRstN), 0);
    check("R6 periphRstN in reset", int'(periphRstN), 0);
    check("R6 pin driven in reset", int'(pinDriveN), 0);
    peek(1'b1, d);
    check("R6 cause in reset", int'(d[2:0]), 0);

    // First release: default stretch 2, release 6 after pin, cause 0
    genRstN = 1'b1;
    countDrive(n);
    check("R8 default stretch", n, 2);
    countToHigh(n);
    check("R4 release after general", n, EXP_RISE);
    check("R4 periph released", int'(periphRstN), 1);
    peek(1'b1, d);
    check("R6 cause general", int'(d[2:0]), 0);

    // Mode register (R13)
    writeMode(32'h0000_0031);
    peek(1'b0, d);
    check("R13 mode readback", int'(d), 32'h31);

    // User reset disabled (R1), pin mirror (R2)
    writeMode(32'h0000_0000);
    extN = 1'b0;
    stayed = 1;
    for (int i = 0; i < 8; i++) begin tick(); if (!procRstN) stayed = 0; end
    check("R1 no reset when disabled", stayed, 1);
    peek(1'b1, d);
    check("R2 status pin bit low", int'(d[16]), 0);
    extN = 1'b1;
    tick(); tick(); tick();
    peek(1'b1, d);
    check("R2 status pin bit high", int'(d[16]), 1);

    // Backup sequences over a table of stretch settings (R7, R8, R4, R10)
    for (int v = 0; v < VEC_N; v++) begin
      writeMode((32'(vecLen[v]) << 4) | 32'h1);
      bkupRst = 1'b1;
      tick();
      bkupRst = 1'b0;
      check("R7 backup asserts reset", int'(procRstN), 0);
      countDrive(n);
      check("R8 stretch length", n, vecLow[v]);
      countToHigh(n);
      check("R4 release after backup", n, EXP_RISE);
      peek(1'b1, d);
      check("R7 cause backup", int'(d[2:0]), 1);
      stayed = 1;
      for (int i = 0; i < 8; i++) begin tick(); if (!procRstN) stayed = 0; end
      check("R10 no user reset from own drive", stayed, 1);
    end

    // User reset (R3, R4, R5, R12)
    writeMode(32'h0000_0001);
    extN = 1'b0;
    countToLow(n);
    check("R3 user entry latency", n, EXP_ENTRY);
    check("R3 periph asserted", int'(periphRstN), 0);
    stayed = 1;
    for (int i = 0; i < 5; i++) begin tick(); if (!pinDriveN) stayed = 0; end
    check("R3 user reset does not drive pin", stayed, 1);
    extN = 1'b1;
    countToHigh(n);
    check("R4 release after user", n, EXP_RISE);
    peek(1'b1, d);
    check("R5 cause user", int'(d[2:0]), 4);
    check("R5 sticky set", int'(d[8]), 1);
    regRe = 1'b1;
    tick();
    regRe = 1'b0;
    peek(1'b1, d);
    check("R12 sticky cleared by read", int'(d[8]), 0);

    // Pin held low from outside past the stretch (R9)
    bkupRst = 1'b1;
    extN = 1'b0;
    tick();
    bkupRst = 1'b0;
    stayed = 1;
    for (int i = 0; i < 20; i++) begin tick(); if (procRstN) stayed = 0; end
    check("R9 held while pin low", stayed, 1);
    extN = 1'b1;
    countToHigh(n);
    check("R9 release after pin rises", n, EXP_RISE);
    peek(1'b1, d);
    check("R9 cause backup", int'(d[2:0]), 1);
    check("R9 no sticky", int'(d[8]), 0);

    // Backup preempts user sequence (R11)
    extN = 1'b0;
    countToLow(n);
    bkupRst = 1'b1;
    tick();
    bkupRst = 1'b0;
    check("R11 backup drives pin in user seq", int'(pinDriveN), 0);
    extN = 1'b1;
    countDrive(n);
    countToHigh(n);
    peek(1'b1, d);
    check("R11 cause backup over user", int'(d[2:0]), 1);

    // Backup ignored during general sequence (R11, R6)
    genRstN = 1'b0;
    tick(); tick();
    genRstN = 1'b1;
    bkupRst = 1'b1;
    tick();
    bkupRst = 1'b0;
    countDrive(n);
    check("R11 general stretch not restarted", n + 1, 2);
    countToHigh(n);
    check("R4 release after second general", n, EXP_RISE);
    peek(1'b1, d);
    check("R6 cause general again", int'(d[2:0]), 0);
    peek(1'b0, d);
    check("R6 mode cleared", int'(d), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule